// File: doc/BRIEF.md
# Scan chain flush integrity checker

This block confirms that a scan chain can shift data end to end before any logic test relies on it. When started, it holds the chain in shift mode and drives a fixed stream of alternating bits, 0 first, into the chain's serial input. It then watches the chain's serial output and expects the same stream back, delayed by exactly the chain length. A stuck link in the chain breaks the alternating rhythm, usually by pinning the output to one value. The checker then reports a failure and the first shift cycle at which the output disagreed.

The chain length is a parameter. The comparison window is a second parameter and defaults to twice the chain length. With that window, a stuck-at-0 or a stuck-at-1 at any cell produces at least one disagreement. The checker reports pass or fail. It does not locate the faulty cell.

Top module: `scan_flush_checker`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and after it is released, the block is idle and all outputs are 0.
- R2: A start pulse sampled while idle or done makes scan enable and busy high from the next cycle onward, for exactly CHAIN_LEN+COMPARE_LEN consecutive cycles. These are the shift cycles, numbered k = 0, 1, 2, ...
- R3: In shift cycle k the serial input bit is k mod 2, so the stream starts with 0. Outside shift cycles the serial input bit is 0.
- R4: The output is compared only in shift cycles k >= CHAIN_LEN, against the bit driven in shift cycle k-CHAIN_LEN. Chain output in earlier shift cycles has no effect on the result.
- R5: The first disagreement in a run latches the failure and reports its shift cycle number k on fail_cycle. Later disagreements in the same run leave fail_cycle unchanged. fail_cycle is 0 when no disagreement has occurred.
- R6: After the last shift cycle, done goes high and stays high until the next accepted start. pass equals done with no disagreement in the run.
- R7: A start pulse during shift cycles is ignored. The run keeps its length and its result.
- R8: A start accepted while done clears done, pass and fail_cycle and begins a fresh run.
- R9: With the default window, a chain with a stuck-at-0 or a stuck-at-1 at any cell is reported as failing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a flush run |
| scan_out_i | input | 1 | Serial output bit of the chain under test |
| scan_in_o | output | 1 | Serial input bit driven into the chain |
| scan_en_o | output | 1 | Scan enable for the chain, high while shifting |
| busy_o | output | 1 | High during shift cycles |
| done_o | output | 1 | High from the end of a run until the next start |
| pass_o | output | 1 | High when done and no disagreement was seen |
| fail_cycle_o | output | CNT_W = ceil(log2(CHAIN_LEN+COMPARE_LEN)) | Shift cycle number of the first disagreement |

## Verification
The bench builds the checker with CHAIN_LEN = 5 and COMPARE_LEN = 10. The odd length means the expected output is in antiphase with the driven stream, so any error in the delay shows up at once. The short length lets a fifteen-cycle run place stuck faults at the first, middle and last cells. A stuck-at-1 is expected to fail at cycle 5 and a stuck-at-0 at cycle 6. The chain is preloaded with ones before a clean run, so the fill cycles carry disagreeing data that must be ignored. Start pulses arrive both during a run and after a failed run.

// File: rtl/scan_flush_pkg.sv
package scan_flush_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_SHIFT = 2'd1,
        FL_DONE  = 2'd2
    } flush_state_e;

endpackage

// File: rtl/flush_stim_gen.sv
// Alternating stimulus source: 0 right after clear, toggles on each shift.
module flush_stim_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv_i,
    output logic bit_o
);
    logic tgl_d, tgl_q;

    always_comb begin
        tgl_d = tgl_q;
        if (clear_i) begin
            tgl_d = 1'b0;
        end else if (adv_i) begin
            tgl_d = ~tgl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= tgl_d;
        end
    end

    assign bit_o = tgl_q;
endmodule

// File: rtl/flush_ref_delay.sv
// Reference line: delays the stimulus by DEPTH shifts, like an ideal chain.
module flush_ref_delay #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic bit_i,
    output logic bit_o
);
    logic [DEPTH-1:0] line_d, line_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                line_d = line_q;
                if (adv_i) begin
                    line_d = bit_i;
                end
            end
        end else begin : g_multi
            always_comb begin
                line_d = line_q;
                if (adv_i) begin
                    line_d = {line_q[DEPTH-2:0], bit_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign bit_o = line_q[DEPTH-1];
endmodule

// File: rtl/flush_mismatch_trap.sv
// Latches the first disagreement of a run and the cycle it happened in.
module flush_mismatch_trap #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          cmp_en_i,
    input  logic          obs_i,
    input  logic          exp_i,
    input  logic [CW-1:0] cycle_i,
    output logic          fail_o,
    output logic [CW-1:0] fail_cycle_o
);
    typedef struct packed {
        logic          fail;
        logic [CW-1:0] cyc;
    } trap_t;

    trap_t trap_d, trap_q;

    always_comb begin
        trap_d = trap_q;
        if (clear_i) begin
            trap_d.fail = 1'b0;
            trap_d.cyc  = '0;
        end else if (cmp_en_i && (obs_i != exp_i) && !trap_q.fail) begin
            trap_d.fail = 1'b1;
            trap_d.cyc  = cycle_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_q <= '0;
        end else begin
            trap_q <= trap_d;
        end
    end

    assign fail_o       = trap_q.fail;
    assign fail_cycle_o = trap_q.cyc;
endmodule

// File: rtl/scan_flush_checker.sv
module scan_flush_checker
    import scan_flush_pkg::*;
#(
    parameter int CHAIN_LEN   = 16,
    parameter int COMPARE_LEN = 2 * CHAIN_LEN,
    localparam int CNT_W      = $clog2(CHAIN_LEN + COMPARE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             scan_out_i,
    output logic             scan_in_o,
    output logic             scan_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic [CNT_W-1:0] fail_cycle_o
);
    localparam int              TOTAL     = CHAIN_LEN + COMPARE_LEN;
    localparam logic [CNT_W-1:0] CMP_START = CNT_W'(CHAIN_LEN);
    localparam logic [CNT_W-1:0] LAST_CYC  = CNT_W'(TOTAL - 1);

    typedef struct packed {
        flush_state_e     state;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic shifting;
    logic clear;
    logic cmp_en;
    logic stim_bit;
    logic ref_bit;
    logic fail;

    assign shifting = (ctl_q.state == FL_SHIFT);
    assign clear    = !shifting && start_i;
    assign cmp_en   = shifting && (ctl_q.cnt >= CMP_START);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            FL_IDLE, FL_DONE: begin
                if (start_i) begin
                    ctl_d.state = FL_SHIFT;
                    ctl_d.cnt   = '0;
                end
            end
            FL_SHIFT: begin
                if (ctl_q.cnt == LAST_CYC) begin
                    ctl_d.state = FL_DONE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctl_d.state = FL_IDLE;
                ctl_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= FL_IDLE;
            ctl_q.cnt   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    flush_stim_gen u_stim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .adv_i   (shifting),
        .bit_o   (stim_bit)
    );

    flush_ref_delay #(
        .DEPTH (CHAIN_LEN)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (shifting),
        .bit_i (stim_bit),
        .bit_o (ref_bit)
    );

    flush_mismatch_trap #(
        .CW (CNT_W)
    ) u_trap (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .cmp_en_i     (cmp_en),
        .obs_i        (scan_out_i),
        .exp_i        (ref_bit),
        .cycle_i      (ctl_q.cnt),
        .fail_o       (fail),
        .fail_cycle_o (fail_cycle_o)
    );

    assign scan_in_o = shifting & stim_bit;
    assign scan_en_o = shifting;
    assign busy_o    = shifting;
    assign done_o    = (ctl_q.state == FL_DONE);
    assign pass_o    = done_o & ~fail;
endmodule

// File: rtl/scan_flush_checker_sva.sv
module scan_flush_checker_sva #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             scan_in_o,
    input logic             scan_en_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             pass_o,
    input logic [CNT_W-1:0] fail_cycle_o
);
    // R3
    first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !scan_in_o);

    // R3
    stream_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (scan_in_o != $past(scan_in_o)));

    // R2
    shift_enable_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> scan_en_o);

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R6
    done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R6
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (done_o && !busy_o));

    // R5
    first_fail_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && ($past(fail_cycle_o) != '0)) |-> $stable(fail_cycle_o));
endmodule

bind scan_flush_checker scan_flush_checker_sva #(
    .CNT_W (CNT_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .scan_in_o    (scan_in_o),
    .scan_en_o    (scan_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .fail_cycle_o (fail_cycle_o)
);

// File: tb/scan_flush_checker_tb.sv
module scan_flush_checker_tb;
    localparam int L     = 5;
    localparam int CMP   = 10;
    localparam int TOTAL = L + CMP;
    localparam int CW    = $clog2(TOTAL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scan_out;
    logic scan_in, scan_en, busy, done, pass;
    logic [CW-1:0] fail_cycle;

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // chain under test, with an injectable stuck cell
    logic [L-1:0] chain_q = '0;
    logic [L-1:0] chain_eff;
    bit flt_en  = 0;
    int flt_pos = 0;
    bit flt_val = 0;

    always_comb begin
        chain_eff = chain_q;
        if (flt_en) chain_eff[flt_pos] = flt_val;
    end
    assign scan_out = chain_eff[L-1];

    always @(posedge clk) begin
        if (scan_en) chain_q <= {chain_eff[L-2:0], scan_in};
    end

    scan_flush_checker #(
        .CHAIN_LEN   (L),
        .COMPARE_LEN (CMP)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .scan_out_i   (scan_out),
        .scan_in_o    (scan_in),
        .scan_en_o    (scan_en),
        .busy_o       (busy),
        .done_o       (done),
        .pass_o       (pass),
        .fail_cycle_o (fail_cycle)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_tb();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // behavioural reference, compared every cycle
    bit m_busy = 0, m_done = 0, m_fail = 0;
    int m_cnt = 0, m_fc = 0;
    int stim_q[$];

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fail = 0; m_cnt = 0; m_fc = 0;
            stim_q.delete();
        end else begin
            chk("R3", "scan_in", int'(scan_in), m_busy ? (m_cnt % 2) : 0);
            chk("R2", "scan_en", int'(scan_en), int'(m_busy));
            chk("R2", "busy", int'(busy), int'(m_busy));
            chk("R6", "done", int'(done), int'(m_done));
            chk("R6", "pass", int'(pass), int'(m_done && !m_fail));
            chk("R5", "fail_cycle", int'(fail_cycle), m_fc);
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_done = 0; m_fail = 0; m_cnt = 0; m_fc = 0;
                    stim_q.delete();
                end
            end else begin
                stim_q.push_back(m_cnt % 2);
                if (m_cnt >= L) begin
                    if ((int'(scan_out) != stim_q[m_cnt - L]) && !m_fail) begin
                        m_fail = 1;
                        m_fc   = m_cnt;
                    end
                end
                if (m_cnt == TOTAL - 1) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    // runs one flush, optionally poking start mid-run; returns busy length
    task automatic run_flush(input bit poke, output int busy_len);
        busy_len = 0;
        pulse_start();
        while (!done) begin
            @(negedge clk);
            if (busy) busy_len++;
            if (poke && busy_len == 6) begin
                #1 start = 1'b1;
                @(posedge clk); #1 start = 1'b0;
            end
        end
    endtask

    initial begin
        int blen;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "scan_en in reset", int'(scan_en), 0);
        chk("R1", "done in reset", int'(done), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "scan_in idle", int'(scan_in), 0);
        chk("R1", "pass idle", int'(pass), 0);

        // R4: chain preloaded with ones, fill output must be ignored; R7 poke
        chain_q = '1;
        run_flush(1'b1, blen);
        chk("R2", "busy length", blen, TOTAL);
        chk("R7", "busy length with poke", blen, TOTAL);
        chk("R4", "clean pass after ones fill", int'(pass), 1);
        repeat (4) @(negedge clk);
        chk("R6", "done held idle", int'(done), 1);

        // R9 / R5: stuck-at-0 in the middle
        flt_en = 1; flt_pos = 2; flt_val = 0;
        run_flush(1'b0, blen);
        chk("R9", "sa0 mid pass", int'(pass), 0);
        chk("R5", "sa0 mid first cycle", int'(fail_cycle), L + 1);

        // R8: restart after failure clears results
        flt_en = 0;
        pulse_start();
        @(negedge clk);
        chk("R8", "done cleared", int'(done), 0);
        chk("R8", "fail_cycle cleared", int'(fail_cycle), 0);
        while (!done) @(negedge clk);
        chk("R8", "pass after restart", int'(pass), 1);

        // R9: stuck-at-1 at first and last cell, stuck-at-0 at last cell
        flt_en = 1; flt_pos = 0; flt_val = 1;
        run_flush(1'b0, blen);
        chk("R9", "sa1 first cell pass", int'(pass), 0);
        chk("R5", "sa1 first cell cycle", int'(fail_cycle), L);

        flt_pos = L - 1; flt_val = 1;
        run_flush(1'b0, blen);
        chk("R9", "sa1 last cell cycle", int'(fail_cycle), L);

        flt_pos = L - 1; flt_val = 0;
        run_flush(1'b0, blen);
        chk("R9", "sa0 last cell pass", int'(pass), 0);
        chk("R5", "sa0 last cell cycle", int'(fail_cycle), L + 1);

        flt_en = 0;
        repeat (3) @(negedge clk);
        finish_tb();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_tb();
    end
endmodule